// File: doc/BRIEF.md
# Isolated Bidirectional Open-Drain Data Repeater

This block is a cycle-based digital model of a repeater that carries an open-drain serial data line, and a one-way clock line, across an isolation barrier. Side A and side B exchange information only through one-bit links, each modelled as a fixed-length delay line. Side A has full drive and samples the resolved bus level, including its own pull-down. Side B has limited drive, so it takes a separate input that reports only lows from external devices and never its own drive. This prevents the repeater from holding itself low.

A low from an external device on side B must last for a filter time before it is accepted. Once accepted, a set/clear latch pulls side B low and sends the low towards side A. The latch clears only when side A's low has made the round trip back. From then on, the returned side A level alone holds side B. Side B is released only after side A has released and that release has come back, so an accepted pulse shows exactly one falling and one rising edge on each side. Lows from any side A device reach side B after the link delay, with no filtering. Each side has a power-good input. A side whose power-good is low releases all of its outputs, and the links it feeds flush to the released level.

Top module: `iso_data_repeater`

## Requirements
- R1: `b_sda_ext_low` high (1 = an external device pulls side B low) is accepted only after it has been sampled high on FILT_CYC consecutive clock edges. A shorter low produces no edge on side A.
- R2: An accepted side B low drives `b_sda_drive_low` high on the same edge. `a_sda_drive_low` rises exactly LINK_DLY edges later, so the total is FILT_CYC + LINK_DLY edges after the first edge that sampled the low.
- R3: The side B latch clears on the edge after the returned low arrives over the A-to-B link. Side B stays driven low because of the returned side A level, with no gap in between.
- R4: Only `b_sda_ext_low` can start a side B acceptance. The block's own side B drive is never fed back, so an A-originated low produces no extra pulse on side A.
- R5: A side A low from any device (`a_sda_in` = 0), even a one-cycle low, produces one side B low pulse of the same length, LINK_DLY edges later.
- R6: After the external side B low ends, side A releases first. Side B is released only once the high side A level has returned. Every accepted pulse yields exactly one fall and one rise on each bus.
- R7: The clock is forwarded one way. `b_scl_drive_low` rises exactly LINK_DLY edges after `a_scl_in` goes low, and side B has no clock input.
- R8: While reset or a side's power-good is low, every output on that side is low (released, high impedance).
- R9: While a link's sending side is unpowered, the receiving side sees the released level from the next edge onward.
- R10: If side A is unpowered while a side B low is latched, side B stays low. Once side A powers up, the round trip completes and both sides release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_a_ok | input | 1 | Side A power-good |
| pwr_b_ok | input | 1 | Side B power-good |
| a_sda_in | input | 1 | Resolved side A data bus level (0 = low) |
| a_sda_drive_low | output | 1 | 1 = side A pulls its data bus low |
| a_scl_in | input | 1 | Side A clock bus level (0 = low) |
| b_sda_ext_low | input | 1 | 1 = an external device pulls side B data low |
| b_sda_drive_low | output | 1 | 1 = side B pulls its data bus low |
| b_scl_drive_low | output | 1 | 1 = side B pulls its clock bus low |

## Verification
The hardest state to reach is a side B low that is latched while side A is unpowered. Both links must stay frozen in a half-completed round trip for an arbitrary time, and then complete cleanly. The bench removes side A power and applies a side B pulse just long enough to pass the filter. It then holds the stall for dozens of cycles before restoring power, and counts the edges on both wired-AND buses to confirm that exactly one pulse appears on each side. Pulses exactly at, one below and far above the filter length exercise the short-pulse path, where the latch alone stretches the low.

// File: rtl/iso_rep_pkg.sv
package iso_rep_pkg;
    // Level carried by a link when nothing is asserted or the sender is down.
    localparam logic LINE_RELEASED = 1'b1;

    // Registered side B control state.
    typedef struct packed {
        logic hold;     // set/clear confirmation latch
    } bside_state_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/iso_link_delay.sv
module iso_link_delay #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ok,
    input  logic din,
    output logic dout
);
    import iso_rep_pkg::*;

    logic [DEPTH-1:0] sr_d, sr_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                sr_d = src_ok ? din : LINE_RELEASED;
            end
        end else begin : g_chain
            always_comb begin
                if (src_ok) sr_d = {sr_q[DEPTH-2:0], din};
                else        sr_d = {DEPTH{LINE_RELEASED}};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= {DEPTH{LINE_RELEASED}};
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[DEPTH-1];

    // R9: an unpowered sender is seen as released from the next edge on
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |=> dout);
endmodule

// File: rtl/iso_b_filter.sv
module iso_b_filter #(
    parameter int unsigned FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic ext_low,
    output logic accept,
    output logic accept_rise
);
    import iso_rep_pkg::*;

    localparam int unsigned CW = cnt_width(FILT_CYC);
    localparam logic [CW-1:0] FMAX = CW'(FILT_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!pwr_ok || !ext_low) cnt_d = '0;
        else if (cnt_q == FMAX)  cnt_d = cnt_q;
        else                     cnt_d = cnt_q + 1'b1;
        accept_rise = (cnt_d == FMAX) && (cnt_q != FMAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign accept = (cnt_q == FMAX);

    // R1: acceptance implies the external low was present on the last edge
    p_accept_needs_ext_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(ext_low));
    // R4: without an external low nothing is accepted on the next cycle
    p_no_self_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_low |=> !accept);
endmodule

// File: rtl/iso_b_ctrl.sv
module iso_b_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic accept,
    input  logic accept_rise,
    input  logic ret_high,
    output logic tx_high,
    output logic drive_low
);
    import iso_rep_pkg::*;

    bside_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_ok)          st_d.hold = 1'b0;
        else if (accept_rise) st_d.hold = 1'b1;
        else if (!ret_high)   st_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Send low while the external low is accepted or the latch awaits return.
    assign tx_high   = !pwr_ok || !(accept || st_q.hold);
    assign drive_low = pwr_ok && (st_q.hold || !ret_high);

    // R3: a returned low clears the latch on the next edge
    p_latch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !ret_high && !accept_rise) |=> !st_q.hold);
    // R2: an acceptance drives side B low from the following cycle
    p_drive_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_rise && pwr_ok) |=> (drive_low || !pwr_ok));
endmodule

// File: rtl/iso_data_repeater.sv
module iso_data_repeater #(
    parameter int unsigned FILT_CYC = 3,
    parameter int unsigned LINK_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_a_ok,
    input  logic pwr_b_ok,
    input  logic a_sda_in,
    output logic a_sda_drive_low,
    input  logic a_scl_in,
    input  logic b_sda_ext_low,
    output logic b_sda_drive_low,
    output logic b_scl_drive_low
);
    localparam int unsigned N_AB = 2;   // data and clock channels from A to B
    localparam int unsigned CH_SDA = 0;
    localparam int unsigned CH_SCL = 1;

    logic            accept, accept_rise;
    logic            ba_tx, ba_rx;
    logic [N_AB-1:0] ab_tx, ab_rx;

    iso_b_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_b_ok), .ext_low(b_sda_ext_low),
        .accept(accept), .accept_rise(accept_rise)
    );

    iso_b_ctrl u_bctl (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_b_ok), .accept(accept),
        .accept_rise(accept_rise), .ret_high(ab_rx[CH_SDA]),
        .tx_high(ba_tx), .drive_low(b_sda_drive_low)
    );

    iso_link_delay #(.DEPTH(LINK_DLY)) u_link_ba (
        .clk(clk), .rst_n(rst_n), .src_ok(pwr_b_ok), .din(ba_tx), .dout(ba_rx)
    );

    assign ab_tx[CH_SDA] = a_sda_in;
    assign ab_tx[CH_SCL] = a_scl_in;

    genvar ch;
    generate
        for (ch = 0; ch < N_AB; ch++) begin : g_ab
            iso_link_delay #(.DEPTH(LINK_DLY)) u_link_ab (
                .clk(clk), .rst_n(rst_n), .src_ok(pwr_a_ok),
                .din(ab_tx[ch]), .dout(ab_rx[ch])
            );
        end
    endgenerate

    assign a_sda_drive_low = rst_n && pwr_a_ok && !ba_rx;
    assign b_scl_drive_low = rst_n && pwr_b_ok && !ab_rx[CH_SCL];

    // R6: side B lets go only while the returned side A level is high
    p_b_release_needs_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(b_sda_drive_low) && pwr_b_ok) |-> ab_rx[CH_SDA]);
    // R8: an unpowered side A never pulls its bus
    p_a_quiet_unpowered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_a_ok |-> !a_sda_drive_low);
endmodule

// File: tb/iso_data_repeater_test.sv
`timescale 1ns/1ps
module iso_data_repeater_test;
    localparam int FILT = 3;
    localparam int LINK = 4;
    localparam int NV = 6;
    localparam int W_TAB [NV] = '{1, 2, 3, 4, 12, 40};
    localparam bit ACC_TAB [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwr_a = 1'b1, pwr_b = 1'b1;
    logic a_dev_low = 1'b0, a_scl_low = 1'b0, b_ext_low = 1'b0;
    logic a_drv, b_drv, b_scl_drv;
    int checks = 0, errors = 0;
    int a_falls = 0, a_rises = 0, b_falls = 0, b_rises = 0;
    logic a_prev = 1'b0, b_prev = 1'b0;

    always #2.5 clk = ~clk;

    iso_data_repeater #(.FILT_CYC(FILT), .LINK_DLY(LINK)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_a_ok(pwr_a), .pwr_b_ok(pwr_b),
        .a_sda_in(~(a_drv | a_dev_low)), .a_sda_drive_low(a_drv),
        .a_scl_in(~a_scl_low), .b_sda_ext_low(b_ext_low),
        .b_sda_drive_low(b_drv), .b_scl_drive_low(b_scl_drv)
    );

    // wired-AND bus edge monitors
    always @(posedge clk) begin
        #1;
        if (!a_prev && (a_drv | a_dev_low)) a_falls++;
        if (a_prev && !(a_drv | a_dev_low)) a_rises++;
        if (!b_prev && (b_drv | b_ext_low)) b_falls++;
        if (b_prev && !(b_drv | b_ext_low)) b_rises++;
        a_prev = a_drv | a_dev_low;
        b_prev = b_drv | b_ext_low;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_pulse(input int w, input bit acc);
        int af0, ar0, bf0, br0;
        af0 = a_falls; ar0 = a_rises; bf0 = b_falls; br0 = b_rises;
        @(negedge clk); b_ext_low = 1'b1;
        repeat (w) @(negedge clk);
        b_ext_low = 1'b0;
        repeat (120) @(negedge clk);
        chk("R1 side A falls", a_falls - af0, acc ? 1 : 0);
        chk("R6 side A rises", a_rises - ar0, acc ? 1 : 0);
        chk("R6 side B falls", b_falls - bf0, 1);
        chk("R6 side B rises", b_rises - br0, 1);
        chk("R6 both released", int'(a_drv | b_drv), 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int af0, bf0, br0;
        repeat (3) @(negedge clk);
        chk("R8 reset a_sda", int'(a_drv), 0);
        chk("R8 reset b_sda", int'(b_drv), 0);
        chk("R8 reset b_scl", int'(b_scl_drv), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // vector table: pulse width versus acceptance
        for (int i = 0; i < NV; i++) run_pulse(W_TAB[i], ACC_TAB[i]);

        // R2 latency, and R3: no gap while the latch hands over
        b_ext_low = 1'b1;
        for (int k = 1; k <= FILT + 2 * LINK + 3; k++) begin
            @(posedge clk); #1;
            if (k == FILT - 1)        chk("R2 b before accept", int'(b_drv), 0);
            if (k == FILT)            chk("R2 b at accept", int'(b_drv), 1);
            if (k == FILT + LINK - 1) chk("R2 a before link", int'(a_drv), 0);
            if (k == FILT + LINK)     chk("R2 a after link", int'(a_drv), 1);
            if (k >= FILT)            chk("R3 b held", int'(b_drv), 1);
        end
        @(negedge clk); b_ext_low = 1'b0;
        repeat (40) @(negedge clk);

        // R5/R4: one-cycle side A low gives one side B pulse, nothing extra on A
        af0 = a_falls; bf0 = b_falls; br0 = b_rises;
        a_dev_low = 1'b1;
        for (int k = 1; k <= LINK + 1; k++) begin
            @(posedge clk); #1;
            if (k == 1) a_dev_low = 1'b0;
            if (k == LINK - 1) chk("R5 b before link", int'(b_drv), 0);
            if (k == LINK)     chk("R5 b after link", int'(b_drv), 1);
            if (k == LINK + 1) chk("R5 one-cycle width", int'(b_drv), 0);
        end
        repeat (40) @(negedge clk);
        chk("R4 side A single fall", a_falls - af0, 1);
        chk("R5 side B single fall", b_falls - bf0, 1);
        chk("R5 side B single rise", b_rises - br0, 1);

        // R7: clock channel latency
        @(negedge clk); a_scl_low = 1'b1;
        for (int k = 1; k <= LINK; k++) begin
            @(posedge clk); #1;
            if (k == LINK - 1) chk("R7 scl before link", int'(b_scl_drv), 0);
            if (k == LINK)     chk("R7 scl after link", int'(b_scl_drv), 1);
        end
        @(negedge clk); a_scl_low = 1'b0;
        repeat (LINK + 2) @(negedge clk);
        chk("R7 scl released", int'(b_scl_drv), 0);

        // R9: side A power loss flushes the A-to-B links
        a_dev_low = 1'b1; a_scl_low = 1'b1;
        repeat (LINK + 2) @(negedge clk);
        chk("R5 held a low reaches b", int'(b_drv), 1);
        pwr_a = 1'b0;
        @(posedge clk); #1;
        chk("R9 sda flushed", int'(b_drv), 0);
        chk("R9 scl flushed", int'(b_scl_drv), 0);
        @(negedge clk); a_dev_low = 1'b0; a_scl_low = 1'b0;

        // R10: latched side B low while side A is down
        repeat (5) @(negedge clk);
        af0 = a_falls; bf0 = b_falls;
        b_ext_low = 1'b1;
        repeat (FILT) @(negedge clk);
        b_ext_low = 1'b0;
        repeat (60) @(negedge clk);
        chk("R10 b stays latched", int'(b_drv), 1);
        chk("R8 a quiet unpowered", int'(a_drv), 0);
        pwr_a = 1'b1;
        repeat (100) @(negedge clk);
        chk("R10 b released after power", int'(b_drv), 0);
        chk("R10 a released", int'(a_drv), 0);
        chk("R10 single a fall", a_falls - af0, 1);
        chk("R10 single b fall", b_falls - bf0, 1);

        // R8/R9: side B power loss during an accepted low
        b_ext_low = 1'b1;
        repeat (FILT + LINK + 4) @(negedge clk);
        chk("R2 a low before b power loss", int'(a_drv), 1);
        pwr_b = 1'b0; #1;
        chk("R8 b released unpowered", int'(b_drv), 0);
        b_ext_low = 1'b0;
        repeat (LINK + 2) @(negedge clk);
        chk("R9 a released after b flush", int'(a_drv), 0);
        pwr_b = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8 all released after restore", int'(a_drv | b_drv | b_scl_drv), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule